// File: doc/BRIEF.md
# Saturating Signed Adder/Subtractor

This block is a purely combinational two's-complement adder/subtractor with a parameterised word width. It adds or subtracts two signed operands with a carry input. The select input picks the operation. The result is then clamped into a window whose signed upper and lower bounds arrive as inputs at run time, rather than being fixed at the word extremes.

The unclamped result is formed at two bits wider than the word. It therefore never wraps before it is compared with the bounds. Four flags report how the output relates to the bounds. Two flags say the output sits exactly on a bound. The other two say the true result lay strictly beyond a bound and was clamped. The block also exposes the carry into every bit of the word-width addition and the carry out of its top bit. This lets one instance per digit be chained in a larger datapath. The block assumes the upper bound is not below the lower bound. With reversed bounds its output has no defined meaning.

Top module: `sat_addsub`

## Requirements
- R1: With `subtract` = 0 and the true sum A + B + carry_in inside the bounds, `result` equals that sum, with all operands read as signed.
- R2: With `subtract` = 1 and the true difference A − B − carry_in inside the bounds, `result` equals that difference. Here carry_in acts as a borrow.
- R3: When the true result is strictly greater than `limit_hi`, `result` equals `limit_hi` and `over_hi` is 1.
- R4: When the true result is strictly less than `limit_lo`, `result` equals `limit_lo` and `under_lo` is 1.
- R5: `at_hi` is 1 exactly when `result` equals `limit_hi`, and `at_lo` is 1 exactly when `result` equals `limit_lo`. This holds whether the output was clamped or landed there by itself.
- R6: `over_hi` is 0 whenever the true result is at or below `limit_hi`. `under_lo` is 0 whenever it is at or above `limit_lo`. The two are never 1 together.
- R7: `carries[i]` is the carry into bit i of the word-width addition A + B' + c0, where B' is B (add) or ~B (subtract), and c0 is carry_in (add) or ~carry_in (subtract). `carries[0]` equals c0.
- R8: `carry_out` is the carry out of bit WIDTH−1 of the same word-width addition.
- R9: Operands at the word extremes produce the correct clamped result without wrap-around. Examples are the maximum plus the maximum plus one, and the minimum minus the maximum minus one.
- R10: When `limit_hi` equals `limit_lo`, `result` equals that value and both `at_hi` and `at_lo` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand, signed |
| b | input | WIDTH | Second operand, signed |
| carry_in | input | 1 | Carry (add) or borrow (subtract) input |
| subtract | input | 1 | 0: add, 1: subtract |
| limit_hi | input | WIDTH | Signed upper bound |
| limit_lo | input | WIDTH | Signed lower bound |
| result | output | WIDTH | Clamped signed result |
| carry_out | output | 1 | Carry out of the top bit of the word-width addition |
| carries | output | WIDTH | Carry into each bit of the word-width addition |
| at_hi | output | 1 | Result equals the upper bound |
| over_hi | output | 1 | True result was strictly above the upper bound |
| at_lo | output | 1 | Result equals the lower bound |
| under_lo | output | 1 | True result was strictly below the lower bound |

## Verification
The bench sweeps every operand, select and carry combination of a 4-bit instance against every ordered pair of bounds, and computes the expected values with integer arithmetic.

The sweep covers the following corner cases:
- **Extreme operands.** A design whose internal width is too narrow would wrap at these values and clamp to the wrong side.
- **Results exactly on a bound.** A comparison that is off by one would raise the over or under flag, or drop the at flag.
- **Equal bounds.** These would expose a clamp that favours one side.
- **Carry vector in subtract mode.** The bench checks it against an independent ripple model. A wrong carry polarity would shift every carry by one.

// File: rtl/sat_addsub_pkg.sv
// Shared constants and types for the saturating adder/subtractor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sat_addsub_pkg;

    // Extra bits carried above the word so the raw result cannot wrap.
    localparam int GUARD_BITS = 2;

    // Operation selected by the subtract input.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

endpackage

// File: rtl/sat_operand_prep.sv
// Sign-extends both operands to the widened width. Inverts B for subtraction
// and forms the carry into bit 0 (carry for add, inverted borrow for subtract).
// Assumes operands are two's-complement of WIDTH bits.
module sat_operand_prep #(
    parameter int WIDTH = 8,
    parameter int XW    = WIDTH + sat_addsub_pkg::GUARD_BITS
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             carry_in,
    input  logic             subtract,
    output logic [XW-1:0]    a_x,
    output logic [XW-1:0]    b_x,
    output logic             c0
);
    import sat_addsub_pkg::*;

    localparam int EXT = XW - WIDTH;

    op_e op;

    // Decode the operation select.
    assign op = op_e'(subtract);

    // Extend the operands, invert B for subtraction and pick the low carry.
    always_comb begin
        a_x = {{EXT{a[WIDTH-1]}}, a};
        if (op == OP_SUB) begin
            b_x = ~{{EXT{b[WIDTH-1]}}, b};
            c0  = ~carry_in;
        end else begin
            b_x = {{EXT{b[WIDTH-1]}}, b};
            c0  = carry_in;
        end
    end
endmodule

// File: rtl/sat_wide_adder.sv
// Adds the prepared operands at the widened width. Also runs a separate
// word-width addition to report the per-bit carries and the carry out of the
// top word bit. Assumes XW exceeds WIDTH by the guard bits.
module sat_wide_adder #(
    parameter int WIDTH = 8,
    parameter int XW    = WIDTH + sat_addsub_pkg::GUARD_BITS
) (
    input  logic [XW-1:0]    a_x,
    input  logic [XW-1:0]    b_x,
    input  logic             c0,
    output logic [XW-1:0]    sum_x,
    output logic [WIDTH-1:0] carries,
    output logic             carry_out
);
    logic [WIDTH:0] word_sum;

    // Widened sum; its range cannot overflow XW bits.
    assign sum_x = a_x + b_x + {{(XW-1){1'b0}}, c0};

    // Word-width sum with one extra bit to capture the top carry.
    assign word_sum = {1'b0, a_x[WIDTH-1:0]} + {1'b0, b_x[WIDTH-1:0]}
                    + {{WIDTH{1'b0}}, c0};

    assign carry_out = word_sum[WIDTH];

    // Recover the carry into each bit from the operand and sum bits.
    for (genvar i = 0; i < WIDTH; i++) begin : g_carry
        assign carries[i] = a_x[i] ^ b_x[i] ^ word_sum[i];
    end
endmodule

// File: rtl/sat_limit_clamp.sv
// Compares the widened raw result with the signed bounds, clamps it and raises
// the status flags. Assumes limit_hi >= limit_lo; otherwise the output is
// meaningless.
module sat_limit_clamp #(
    parameter int WIDTH = 8,
    parameter int XW    = WIDTH + sat_addsub_pkg::GUARD_BITS
) (
    input  logic [XW-1:0]    sum_x,
    input  logic [WIDTH-1:0] limit_hi,
    input  logic [WIDTH-1:0] limit_lo,
    output logic [WIDTH-1:0] result,
    output logic             at_hi,
    output logic             over_hi,
    output logic             at_lo,
    output logic             under_lo
);
    localparam int EXT = XW - WIDTH;

    logic signed [XW-1:0] raw_s;
    logic signed [XW-1:0] hi_s;
    logic signed [XW-1:0] lo_s;

    // Bring the raw result and both bounds to the same signed width.
    assign raw_s = $signed(sum_x);
    assign hi_s  = $signed({{EXT{limit_hi[WIDTH-1]}}, limit_hi});
    assign lo_s  = $signed({{EXT{limit_lo[WIDTH-1]}}, limit_lo});

    // Clamp against the bounds; the upper bound is tested first.
    always_comb begin
        over_hi  = raw_s > hi_s;
        under_lo = raw_s < lo_s;
        if (over_hi) begin
            result = limit_hi;
        end else if (under_lo) begin
            result = limit_lo;
        end else begin
            result = sum_x[WIDTH-1:0];
        end
    end

    // Report where the final output sits relative to each bound.
    assign at_hi = (result == limit_hi);
    assign at_lo = (result == limit_lo);
endmodule

// File: rtl/sat_addsub.sv
// Saturating signed adder/subtractor, combinational.
// Computes A + B + carry_in (subtract = 0) or A - B - carry_in (subtract = 1)
// at WIDTH + 2 bits, then clamps the result into [limit_lo, limit_hi].
// Assumes limit_hi >= limit_lo. Exposes per-bit carries and the top carry for
// chaining.
module sat_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             carry_in,
    input  logic             subtract,
    input  logic [WIDTH-1:0] limit_hi,
    input  logic [WIDTH-1:0] limit_lo,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic [WIDTH-1:0] carries,
    output logic             at_hi,
    output logic             over_hi,
    output logic             at_lo,
    output logic             under_lo
);
    localparam int XW = WIDTH + sat_addsub_pkg::GUARD_BITS;

    logic [XW-1:0] a_x;
    logic [XW-1:0] b_x;
    logic [XW-1:0] sum_x;
    logic          c0;

    sat_operand_prep #(.WIDTH(WIDTH), .XW(XW)) u_prep (
        .a        (a),
        .b        (b),
        .carry_in (carry_in),
        .subtract (subtract),
        .a_x      (a_x),
        .b_x      (b_x),
        .c0       (c0)
    );

    sat_wide_adder #(.WIDTH(WIDTH), .XW(XW)) u_add (
        .a_x       (a_x),
        .b_x       (b_x),
        .c0        (c0),
        .sum_x     (sum_x),
        .carries   (carries),
        .carry_out (carry_out)
    );

    sat_limit_clamp #(.WIDTH(WIDTH), .XW(XW)) u_clamp (
        .sum_x    (sum_x),
        .limit_hi (limit_hi),
        .limit_lo (limit_lo),
        .result   (result),
        .at_hi    (at_hi),
        .over_hi  (over_hi),
        .at_lo    (at_lo),
        .under_lo (under_lo)
    );

    // Guard the relations between the ports that the submodules produce.
    always_comb begin
        if (!$isunknown({a, b, carry_in, subtract, limit_hi, limit_lo})) begin
            if ($signed(limit_hi) >= $signed(limit_lo)) begin
                a_r3_below_hi: assert ($signed(result) <= $signed(limit_hi))
                    else $error("R3: result above upper bound");
                a_r4_above_lo: assert ($signed(result) >= $signed(limit_lo))
                    else $error("R4: result below lower bound");
                a_r6_flags_exclusive: assert (!(over_hi && under_lo))
                    else $error("R6: over and under both set");
            end
            a_r5_over_lands_hi: assert (!over_hi || at_hi)
                else $error("R5: clamped high but not at bound");
            a_r5_under_lands_lo: assert (!under_lo || at_lo)
                else $error("R5: clamped low but not at bound");
            a_r7_first_carry: assert (carries[0] == (subtract ? ~carry_in : carry_in))
                else $error("R7: carry into bit 0 wrong");
        end
    end
endmodule

// File: tb/tb_sat_addsub.sv
// Near-exhaustive bench for a 4-bit instance. Sweeps all operands, selects,
// carries and every ordered bound pair, against an integer reference.
module tb_sat_addsub;
    localparam int W          = 4;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;
    localparam int SMAX       = (1 << (W - 1)) - 1;
    localparam int SMIN       = -(1 << (W - 1));

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b, limit_hi, limit_lo;
    logic         carry_in, subtract;
    logic [W-1:0] result, carries;
    logic         carry_out, at_hi, over_hi, at_lo, under_lo;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sat_addsub #(.WIDTH(W)) dut (
        .a(a), .b(b), .carry_in(carry_in), .subtract(subtract),
        .limit_hi(limit_hi), .limit_lo(limit_lo),
        .result(result), .carry_out(carry_out), .carries(carries),
        .at_hi(at_hi), .over_hi(over_hi), .at_lo(at_lo), .under_lo(under_lo)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d sub=%0d cin=%0d hi=%0d lo=%0d)",
                     tag, act, exp, a, b, subtract, carry_in, limit_hi, limit_lo);
        end
    endtask

    function automatic int sx(input logic [W-1:0] v);
        return v[W-1] ? int'(v) - (1 << W) : int'(v);
    endfunction

    task automatic run_vec(input int ai, input int bi, input int s, input int c,
                           input int hi, input int lo);
        int raw, exp_y, cc;
        logic [W-1:0] bp, exp_car;
        string ytag;
        a = W'(ai); b = W'(bi); subtract = s[0]; carry_in = c[0];
        limit_hi = W'(hi); limit_lo = W'(lo);
        #1;
        raw = s ? ai - bi - c : ai + bi + c;
        exp_y = (raw > hi) ? hi : ((raw < lo) ? lo : raw);
        if (raw > hi)                                 ytag = "R3 clamp high";
        else if (raw < lo)                            ytag = "R4 clamp low";
        else if (hi == lo)                            ytag = "R10 equal bounds";
        else if (s != 0)                              ytag = "R2 subtract";
        else                                          ytag = "R1 add";
        if (ai == SMAX || ai == SMIN || bi == SMAX || bi == SMIN)
            ytag = {ytag, " R9 extreme"};
        chk(ytag, sx(result), exp_y);
        chk("R5 at_hi", int'(at_hi), int'(exp_y == hi));
        chk("R5 at_lo", int'(at_lo), int'(exp_y == lo));
        chk("R6 over_hi", int'(over_hi), int'(raw > hi));
        chk("R6 under_lo", int'(under_lo), int'(raw < lo));
        if (hi == lo) chk("R10 both at flags", int'(at_hi & at_lo), 1);
        // Independent ripple model for the word-width carries.
        bp = s ? ~W'(bi) : W'(bi);
        cc = s ? 1 - c : c;
        for (int i = 0; i < W; i++) begin
            exp_car[i] = cc[0];
            cc = (a[i] & bp[i]) | (a[i] & cc[0]) | (bp[i] & cc[0]);
        end
        chk("R7 carries", int'(carries), int'(exp_car));
        chk("R8 carry_out", int'(carry_out), cc);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stimulus
        a = '0; b = '0; carry_in = 1'b0; subtract = 1'b0;
        limit_hi = W'(SMAX); limit_lo = W'(SMIN);
        repeat (2) @(negedge clk);
        chk("R1 idle zero result", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed extremes (R9) with the full window.
        run_vec(SMAX, SMAX, 0, 1, SMAX, SMIN);
        run_vec(SMIN, SMAX, 1, 1, SMAX, SMIN);
        run_vec(SMIN, SMIN, 0, 0, SMAX, SMIN);
        run_vec(SMAX, SMIN, 1, 0, SMAX, SMIN);
        // Full sweep over all ordered bound pairs.
        for (int hi = SMIN; hi <= SMAX; hi++) begin
            for (int lo = SMIN; lo <= hi; lo++) begin
                for (int ai = SMIN; ai <= SMAX; ai++) begin
                    for (int bi = SMIN; bi <= SMAX; bi++) begin
                        for (int s = 0; s < 2; s++) begin
                            for (int c = 0; c < 2; c++) begin
                                run_vec(ai, bi, s, c, hi, lo);
                            end
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule